// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block lets a host reach an on-chip register bus through a three-wire serial link made of a chip select, a serial clock and one bidirectional data pin. All three lines are brought into the system clock domain and oversampled there. Edges of the serial clock are found in that domain, and the block drives a plain register bus toward the register file: a 7-bit address, write data, a one-cycle write strobe, a one-cycle read strobe and a read-data return. The data pin is driven back only while a read is in progress, through a separate output enable.

Each access begins with a command byte. Its low seven bits give the starting register and its top bit picks the direction. Any number of data bytes may follow. The address steps after every byte and returns to zero after the last implemented register. The block keeps a copy of the global write-protect flag, which sits in the control register, so it can hold back writes to every other register while the flag is set.

Top module: `tw_reg_slave`

## Requirements
- R1: A transfer starts when chip select rises, and the first eight bits are the command byte. Command bits 6..0 give the start address. Command bit 7 set to 1 selects a write and set to 0 selects a read.
- R2: Command and data bits are taken from the data pin on rising serial-clock edges, least significant bit first.
- R3: After the eighth bit of a write data byte, `reg_wr_o` pulses high for exactly one system-clock cycle, with that byte on `reg_wdata_o` and its address on `reg_addr_o`. If chip select drops with fewer than eight bits of a data byte received, that partial byte causes no write.
- R4: In a read, the falling serial-clock edge that ends the command byte or the previous data byte raises `reg_rd_o` for one cycle. `reg_rdata_i` is captured in that cycle. The byte then appears on `sdio_o` least significant bit first, one bit after each falling edge, with `sdio_oe` high.
- R5: After each full data byte the address advances by one. After 0Eh it goes to 00h, and after 7Fh it also goes to 00h.
- R6: Addresses 0Fh to 7Fh are reserved. A read from them returns 00h on the pin without a read strobe, and a write to them produces no write strobe.
- R7: The control register is at 0Bh and bit 6 of it is the write-protect flag, which reset clears. While the flag is 1, writes to any other address produce no strobe. Writes to 0Bh are always accepted and update the flag.
- R8: When chip select is low, `sdio_oe` is low in the same cycle and the transfer in progress is abandoned.
- R9: During and right after reset, `sdio_oe`, `reg_wr_o` and `reg_rd_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Chip select, high during a transfer |
| sclk_i | input | 1 | Serial clock from the host |
| sdio_i | input | 1 | Data pin level as seen at the pad |
| sdio_o | output | 1 | Data bit driven toward the pad |
| sdio_oe | output | 1 | Output enable of the data pad |
| reg_addr_o | output | 7 | Register bus address |
| reg_wdata_o | output | 8 | Register bus write data |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 8 | Read data, valid in the cycle of `reg_rd_o` |

## Verification
A bit counter that is off by one shows up within the first data byte. Writes land one register over or carry a byte shifted by one bit, and read bytes come back rotated on the pin. A wrong address register or wrap rule shows on the next byte of a burst as data from the wrong register or as a strobe at a reserved address. A stale write-protect copy shows on the first write after the control register changes, as a missing or extra strobe. A bad output enable is visible on the very next cycle after chip select drops.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } tw_phase_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_chain
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tw_rx.sv
module tw_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] byte_o,
  output logic         first_o,
  output logic         last_o
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sr_q, sr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (clr) begin
      sr_d  = '0;
      cnt_d = '0;
    end else if (shift) begin
      sr_d  = {din, sr_q[W-1:1]};
      cnt_d = (cnt_q == CW'(W-1)) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  // byte as it stands once the bit now on din is shifted in
  assign byte_o  = {din, sr_q[W-1:1]};
  assign first_o = (cnt_q == '0);
  assign last_o  = (cnt_q == CW'(W-1));
endmodule

// File: rtl/tw_tx.sv
module tw_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] data_i,
  output logic         bit_o
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load)       sr_d = data_i;
    else if (shift) sr_d = {1'b0, sr_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign bit_o = sr_q[0];
endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave
  import tw_pkg::*;
#(
  parameter int                ADDR_W      = 7,
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] LAST_ADDR   = 7'h0E,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 7'h0B,
  parameter int                WP_BIT      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              sclk_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int RW_BIT = DATA_W - 1;

  logic [2:0] synced;
  logic       sel_s, sclk_s, din_s;

  tw_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({sel_i, sclk_i, sdio_i}),
    .q_o   (synced)
  );
  assign {sel_s, sclk_s, din_s} = synced;

  tw_phase_t         phase_q, phase_d;
  logic              wmode_q, wmode_d;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_next;
  logic              wp_q, wp_d;
  logic              oe_q, oe_d;
  logic              sclk_q;

  logic              rise, fall;
  logic [DATA_W-1:0] rx_byte;
  logic              rx_first, rx_last;
  logic              cmd_done, data_done, addr_ok, wr_allowed;
  logic              rd_launch, tx_shift;

  assign rise = sel_s &  sclk_s & ~sclk_q;
  assign fall = sel_s & ~sclk_s &  sclk_q;

  tw_rx #(.W(DATA_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (~sel_s),
    .shift   (rise),
    .din     (din_s),
    .byte_o  (rx_byte),
    .first_o (rx_first),
    .last_o  (rx_last)
  );

  assign cmd_done   = rise & (phase_q == PH_CMD)  & rx_last;
  assign data_done  = rise & (phase_q == PH_DATA) & rx_last;
  assign addr_ok    = (addr_q <= LAST_ADDR);
  assign wr_allowed = ~wp_q | (addr_q == CTRL_ADDR);
  assign addr_next  = (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;

  assign rd_launch  = fall & (phase_q == PH_DATA) & ~wmode_q &  rx_first;
  assign tx_shift   = fall & (phase_q == PH_DATA) & ~wmode_q & ~rx_first;

  tw_tx #(.W(DATA_W)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (rd_launch),
    .shift  (tx_shift),
    .data_i (addr_ok ? reg_rdata_i : '0),
    .bit_o  (sdio_o)
  );

  assign reg_wr_o    = data_done & wmode_q & addr_ok & wr_allowed;
  assign reg_rd_o    = rd_launch & addr_ok;
  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = rx_byte;
  assign sdio_oe     = oe_q & sel_i;

  always_comb begin
    phase_d = phase_q;
    wmode_d = wmode_q;
    addr_d  = addr_q;
    wp_d    = wp_q;
    oe_d    = oe_q;
    if (!sel_s) begin
      phase_d = PH_CMD;
      oe_d    = 1'b0;
    end else begin
      if (cmd_done) begin
        phase_d = PH_DATA;
        wmode_d = rx_byte[RW_BIT];
        addr_d  = rx_byte[ADDR_W-1:0];
      end
      if (data_done) addr_d = addr_next;
      if (rd_launch) oe_d = 1'b1;
      if (reg_wr_o && (addr_q == CTRL_ADDR)) wp_d = rx_byte[WP_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      wmode_q <= 1'b0;
      addr_q  <= '0;
      wp_q    <= 1'b0;
      oe_q    <= 1'b0;
      sclk_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      wmode_q <= wmode_d;
      addr_q  <= addr_d;
      wp_q    <= wp_d;
      oe_q    <= oe_d;
      sclk_q  <= sclk_s;
    end
  end
endmodule

// File: rtl/tw_reg_slave_chk.sv
module tw_reg_slave_chk #(
  parameter int                ADDR_W    = 7,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] LAST_ADDR = 7'h0E
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_i,
  input logic              sdio_oe,
  input logic [ADDR_W-1:0] reg_addr_o,
  input logic [DATA_W-1:0] reg_wdata_o,
  input logic              reg_wr_o,
  input logic              reg_rd_o
);
  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o); // R3

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_o && reg_rd_o)); // R4

  AST_RD_DRIVES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_o |=> (sdio_oe || !sel_i)); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> (reg_addr_o == (($past(reg_addr_o) == LAST_ADDR) ? '0
                                 : $past(reg_addr_o) + 1'b1))); // R5

  AST_NO_RSV_WR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> (reg_addr_o <= LAST_ADDR)); // R6

  AST_NO_RSV_RD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_o |-> (reg_addr_o <= LAST_ADDR)); // R6

  AST_WDATA_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> !$isunknown(reg_wdata_o)); // R3
endmodule

bind tw_reg_slave tw_reg_slave_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .LAST_ADDR (LAST_ADDR)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_i       (sel_i),
  .sdio_oe     (sdio_oe),
  .reg_addr_o  (reg_addr_o),
  .reg_wdata_o (reg_wdata_o),
  .reg_wr_o    (reg_wr_o),
  .reg_rd_o    (reg_rd_o)
);

// File: tb/test_tw_reg_slave.sv
module test_tw_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel, sclk, sdio_i;
  logic       sdio_o, sdio_oe;
  logic [6:0] reg_addr_o;
  logic [7:0] reg_wdata_o, reg_rdata_i;
  logic       reg_wr_o, reg_rd_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_reg_slave i_tw_reg_slave (
    .clk (clk), .rst_n (rst_n), .sel_i (sel), .sclk_i (sclk), .sdio_i (sdio_i),
    .sdio_o (sdio_o), .sdio_oe (sdio_oe), .reg_addr_o (reg_addr_o),
    .reg_wdata_o (reg_wdata_o), .reg_wr_o (reg_wr_o), .reg_rd_o (reg_rd_o),
    .reg_rdata_i (reg_rdata_i)
  );

  // register file responder
  logic [7:0] rmem [128];
  assign reg_rdata_i = rmem[reg_addr_o];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) rmem[i] <= 8'h00;
    end else if (reg_wr_o) begin
      rmem[reg_addr_o] <= reg_wdata_o;
    end
  end

  // behavioural reference
  logic [7:0]  emem [128];
  bit          wp_m;
  logic [14:0] wq [$];
  int          exp_rd, rd_cnt, oe_bad;
  int          n_chk, n_fail;
  logic [7:0]  wbuf [8];

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_wr_o) begin
        if (wq.size() == 0) begin
          check(1'b0, "R3/R7 unexpected write", {17'd0, reg_addr_o, reg_wdata_o}, 32'hFFFF);
        end else begin
          logic [14:0] e;
          e = wq.pop_front();
          check({reg_addr_o, reg_wdata_o} == e, "R3 write strobe",
                {17'd0, reg_addr_o, reg_wdata_o}, {17'd0, e});
        end
      end
      if (reg_rd_o) rd_cnt++;
      if (!sel && sdio_oe) oe_bad++;
    end
  end

  task automatic slot(input logic din, output logic dout, output logic oe);
    sdio_i = din;
    repeat (HALF) @(negedge clk);
    dout = sdio_o;
    oe   = sdio_oe;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] cmd, input int nbytes, input int partial,
                      input string req);
    logic [6:0] a;
    logic       b, o;
    logic [7:0] got, exp;
    bit         oe_ok;
    sel = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) slot(cmd[i], b, o);
    a = cmd[6:0];
    for (int k = 0; k < nbytes; k++) begin
      if (cmd[7]) begin
        if (a <= 7'h0E && (!wp_m || a == 7'h0B)) begin
          wq.push_back({a, wbuf[k]});
          emem[a] = wbuf[k];
          if (a == 7'h0B) wp_m = wbuf[k][6];
        end
        for (int i = 0; i < 8; i++) slot(wbuf[k][i], b, o);
      end else begin
        exp = (a <= 7'h0E) ? emem[a] : 8'h00;
        if (a <= 7'h0E) exp_rd++;
        oe_ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
          slot(1'b0, b, o);
          got[i] = b;
          if (!o) oe_ok = 1'b0;
        end
        check(got == exp, req, {24'd0, got}, {24'd0, exp});
        check(oe_ok, "R4 output enable during read", {31'd0, oe_ok}, 1);
      end
      a = (a == 7'h0E) ? 7'h00 : a + 7'd1;
    end
    if (partial > 0 && !cmd[7] && a <= 7'h0E) exp_rd++;
    for (int i = 0; i < partial; i++) slot(wbuf[nbytes][i], b, o);
    sel = 1'b0;
    @(negedge clk);
    check(!sdio_oe, "R8 pin released with select low", {31'd0, sdio_oe}, 0);
    repeat (6) @(negedge clk);
    check(wq.size() == 0, "R3 all expected writes seen", wq.size(), 0);
    check(rd_cnt == exp_rd, "R4/R6 read strobe count", rd_cnt, exp_rd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) emem[i] = 8'h00;
    wp_m = 1'b0; exp_rd = 0; rd_cnt = 0; oe_bad = 0; n_chk = 0; n_fail = 0;
    rst_n = 1'b0; sel = 1'b0; sclk = 1'b0; sdio_i = 1'b0;
    repeat (5) @(negedge clk);
    check(!sdio_oe && !reg_wr_o && !reg_rd_o, "R9 reset outputs quiet",
          {29'd0, sdio_oe, reg_wr_o, reg_rd_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!sdio_oe && !reg_wr_o && !reg_rd_o, "R9 idle after reset",
          {29'd0, sdio_oe, reg_wr_o, reg_rd_o}, 0);

    // R1 R2 R3: single write, then single read (R4)
    wbuf[0] = 8'h5A; xfer(8'h83, 1, 0, "R1 single write");
    xfer(8'h03, 1, 0, "R4 single read");

    // R2: asymmetric patterns expose bit order
    wbuf[0] = 8'h01; wbuf[1] = 8'h80; xfer(8'h85, 2, 0, "R2 burst write");
    xfer(8'h05, 2, 0, "R2 lsb-first readback");

    // R5: burst write and read across the 0Eh wrap
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    xfer(8'h8D, 3, 0, "R5 wrap write");
    xfer(8'h8D & 8'h7F, 3, 0, "R5 wrap read");

    // R6: reserved addresses, and 7Fh wraps to 00h
    wbuf[0] = 8'h77; xfer(8'hA0, 1, 0, "R6 reserved write");
    xfer(8'h7F, 2, 0, "R6 reserved read then wrap");
    xfer(8'h20, 1, 0, "R6 reserved read after write");

    // R7: write protect
    wbuf[0] = 8'h40; xfer(8'h8B, 1, 0, "R7 set protect");
    wbuf[0] = 8'h99; xfer(8'h82, 1, 0, "R7 blocked write");
    xfer(8'h02, 1, 0, "R7 blocked register unchanged");
    wbuf[0] = 8'h00; xfer(8'h8B, 1, 0, "R7 clear protect");
    wbuf[0] = 8'h99; xfer(8'h82, 1, 0, "R7 write after clear");
    xfer(8'h02, 1, 0, "R7 readback");

    // R3: partial bytes discarded
    wbuf[0] = 8'hC3; xfer(8'h84, 0, 5, "R3 partial only");
    wbuf[0] = 8'h3C; wbuf[1] = 8'hFF; xfer(8'h84, 1, 3, "R3 one full one partial");
    xfer(8'h04, 2, 0, "R3 partial left register 05h");

    // R8: read aborted mid-byte
    xfer(8'h03, 0, 3, "R8 aborted read");
    xfer(8'h03, 1, 0, "R8 clean read after abort");

    check(oe_bad == 0, "R8 enable never high with select low", oe_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule